// File: doc/BRIEF.md
# FIFO ECC Error Counter Bank

This block collects error reports from the ECC checkers of three protected FIFOs inside a communication controller. The FIFOs are a first transmit FIFO (index 0), a second transmit FIFO (index 1) and a receive FIFO (index 2). Each checker sends one-cycle pulses: one kind for a corrected single-bit error and one kind for an uncorrectable double-bit error. For every FIFO and every error class, the bank keeps a saturating 16-bit count.

Each report also sets a sticky interrupt status bit. An enable register masks these bits, and the enabled bits are combined into a single interrupt line. Software reaches the bank through a plain 32-bit register port: a write strobe, an address and write data, with read data returned combinationally from the address. Software acknowledges events with write-one-to-clear. A self-clearing configuration register resets the two counts of any chosen FIFO.

Top module: `fifo_ecc_errbank`

## Requirements
- R1: Counter words sit at 0xCC (FIFO 0), 0xD0 (FIFO 1) and 0xD4 (FIFO 2). Bits [15:0] hold the single-bit count and bits [31:16] hold the double-bit count.
- R2: Each cycle with `sbe_pulse[f]` (or `dbe_pulse[f]`) high raises the matching count of FIFO f by one. Pulses of both classes in the same cycle raise both counts.
- R3: A count that has reached 0xFFFF stays at 0xFFFF under further pulses and never wraps.
- R4: A write to 0xC8 with bit f set clears both counts of FIFO f: bit 0 for FIFO 0, bit 1 for FIFO 1, bit 2 for FIFO 2. Counts of FIFOs whose bit is 0 are unchanged. The register always reads 0.
- R5: When a count reset and a pulse for that count fall in the same cycle, the count ends at 0.
- R6: The status register at 0x1C holds sticky bits. Bit 18+2f is set by a single-bit pulse of FIFO f and bit 19+2f by a double-bit pulse. Every other bit reads 0.
- R7: Writing ones to 0x24 clears the status bits at the same positions. A pulse that arrives in the same cycle as its clear leaves the bit set.
- R8: The enable register at 0x20 is read/write on bits [23:18] only. `irq` is high exactly when some status bit is set together with its enable bit.
- R9: Writes to the counter words and to the status register have no effect. Any offset outside the map reads 0.
- R10: After synchronous active-low reset, all counts, status bits and enable bits are 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| sbe_pulse | input | 3 | Single-bit error pulse per FIFO |
| dbe_pulse | input | 3 | Double-bit error pulse per FIFO |
| irq | output | 1 | Interrupt: OR of enabled pending status bits |

## Verification
The embedded assertions check the following on every cycle:
- each count steps by exactly one per pulse below the limit;
- a count at the limit holds;
- a configuration reset wins over a same-cycle pulse;
- each pulse leaves its status bit set;
- an enabled event raises `irq`;
- the configuration register reads 0.

Some behaviours can only be shown by the bench scenarios, because they depend on the register map:
- the packing of both counts into the right word at the right offset;
- the per-FIFO selectivity of the reset bits;
- the set-wins rule on a clear;
- the masking of enable bits;
- ignored writes to read-only words;
- zero reads at unmapped offsets.

// File: rtl/fifo_ecc_errbank.sv
module fifo_ecc_errbank #(
  parameter int NFIFO    = 3,
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = 12,
  parameter int DW       = 32,
  parameter int STAT_LSB = 18,
  parameter logic [ADDR_W-1:0] OFS_STAT = 12'h01C,
  parameter logic [ADDR_W-1:0] OFS_ENA  = 12'h020,
  parameter logic [ADDR_W-1:0] OFS_ACK  = 12'h024,
  parameter logic [ADDR_W-1:0] OFS_CFG  = 12'h0C8,
  parameter logic [ADDR_W-1:0] OFS_CNT0 = 12'h0CC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [NFIFO-1:0]  sbe_pulse,
  input  logic [NFIFO-1:0]  dbe_pulse,
  output logic              irq
);

  localparam int NEV = 2 * NFIFO;
  localparam int HALF = DW / 2;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [NEV-1:0]   ev, pend, ena, ack;
  logic [NFIFO-1:0] cfg_clr;
  logic [CNT_W-1:0] sbe_cnt [NFIFO];
  logic [CNT_W-1:0] dbe_cnt [NFIFO];

  wire wr_cfg = reg_wr && (reg_addr == OFS_CFG);
  wire wr_ena = reg_wr && (reg_addr == OFS_ENA);
  wire wr_ack = reg_wr && (reg_addr == OFS_ACK);

  assign cfg_clr = wr_cfg ? reg_wdata[NFIFO-1:0] : '0;
  assign ack     = wr_ack ? reg_wdata[STAT_LSB +: NEV] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      ena  <= '0;
    end else begin
      pend <= (pend & ~ack) | ev;
      if (wr_ena) ena <= reg_wdata[STAT_LSB +: NEV];
    end
  end

  assign irq = |(pend & ena);

  for (genvar f = 0; f < NFIFO; f++) begin : g_fifo
    assign ev[2*f]   = sbe_pulse[f];
    assign ev[2*f+1] = dbe_pulse[f];

    always_ff @(posedge clk) begin
      if (!rst_n || cfg_clr[f]) begin
        sbe_cnt[f] <= '0;
        dbe_cnt[f] <= '0;
      end else begin
        if (sbe_pulse[f] && sbe_cnt[f] != CMAX) sbe_cnt[f] <= sbe_cnt[f] + 1'b1;
        if (dbe_pulse[f] && dbe_cnt[f] != CMAX) dbe_cnt[f] <= dbe_cnt[f] + 1'b1;
      end
    end

    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sbe_pulse[f] && !cfg_clr[f] && sbe_cnt[f] != CMAX)
        |=> sbe_cnt[f] == CNT_W'($past(sbe_cnt[f]) + 1'b1));
    assert_dbe_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (dbe_pulse[f] && !cfg_clr[f] && dbe_cnt[f] != CMAX)
        |=> dbe_cnt[f] == CNT_W'($past(dbe_cnt[f]) + 1'b1));
    assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sbe_cnt[f] == CMAX && !cfg_clr[f]) |=> sbe_cnt[f] == CMAX);
    assert_clr_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_clr[f] |=> (sbe_cnt[f] == '0 && dbe_cnt[f] == '0));
  end

  for (genvar i = 0; i < NEV; i++) begin : g_ev
    assert_sticky_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ev[i] |=> pend[i]);
    assert_irq_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ev[i] && ena[i] && !wr_ena) |=> irq);
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFS_STAT) reg_rdata[STAT_LSB +: NEV] = pend;
    if (reg_addr == OFS_ENA)  reg_rdata[STAT_LSB +: NEV] = ena;
    for (int f = 0; f < NFIFO; f++) begin
      if (reg_addr == OFS_CNT0 + ADDR_W'(4 * f)) begin
        reg_rdata[CNT_W-1:0]     = sbe_cnt[f];
        reg_rdata[HALF +: CNT_W] = dbe_cnt[f];
      end
    end
  end

  assert_cfg_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == OFS_CFG) |-> reg_rdata == '0);

endmodule

// File: tb/fifo_ecc_errbank_tb.sv
module fifo_ecc_errbank_tb_top;
  logic clk = 0, rst_n = 0, reg_wr = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [2:0] sbe_pulse = '0, dbe_pulse = '0;
  logic irq;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  fifo_ecc_errbank dut_i (.clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata,
    .reg_rdata, .sbe_pulse, .dbe_pulse, .irq);

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
    @(negedge clk); reg_addr = a; #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic pulse(logic [2:0] s, logic [2:0] d);
    @(negedge clk); sbe_pulse = s; dbe_pulse = d;
    @(negedge clk); sbe_pulse = '0; dbe_pulse = '0;
  endtask

  task automatic t_reset;
    rd_chk("R10 cnt0", 12'h0CC, 0); rd_chk("R10 cnt1", 12'h0D0, 0);
    rd_chk("R10 cnt2", 12'h0D4, 0); rd_chk("R10 stat", 12'h01C, 0);
    rd_chk("R10 ena", 12'h020, 0); check("R10 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_count;
    repeat (3) pulse(3'b001, 3'b000);
    repeat (2) pulse(3'b000, 3'b001);
    repeat (4) pulse(3'b000, 3'b010);
    pulse(3'b100, 3'b000);
    rd_chk("R1 R2 fifo0", 12'h0CC, 32'h0002_0003);
    rd_chk("R1 R2 fifo1", 12'h0D0, 32'h0004_0000);
    rd_chk("R1 R2 fifo2", 12'h0D4, 32'h0000_0001);
    pulse(3'b100, 3'b100);
    rd_chk("R2 both classes", 12'h0D4, 32'h0001_0002);
  endtask

  task automatic t_status;
    rd_chk("R6 sticky bits", 12'h01C, 32'h00EC_0000);
    wr(12'h01C, 32'h0);
    rd_chk("R9 status write ignored", 12'h01C, 32'h00EC_0000);
  endtask

  task automatic t_clear;
    wr(12'h024, 32'h0040_0000);
    rd_chk("R7 partial clear", 12'h01C, 32'h00AC_0000);
    wr(12'h024, 32'hFFFF_FFFF);
    rd_chk("R7 full clear", 12'h01C, 0);
    @(negedge clk); reg_wr = 1; reg_addr = 12'h024; reg_wdata = 32'h0010_0000;
    sbe_pulse = 3'b010;
    @(negedge clk); reg_wr = 0; sbe_pulse = '0;
    rd_chk("R7 set wins", 12'h01C, 32'h0010_0000);
    wr(12'h024, 32'h0010_0000);
  endtask

  task automatic t_cfg;
    wr(12'h0C8, 32'h2);
    rd_chk("R4 fifo1 cleared", 12'h0D0, 0);
    rd_chk("R4 fifo0 kept", 12'h0CC, 32'h0002_0003);
    rd_chk("R4 fifo2 kept", 12'h0D4, 32'h0001_0002);
    rd_chk("R4 cfg reads 0", 12'h0C8, 0);
    wr(12'h0C8, 32'h5);
    rd_chk("R4 fifo0 cleared", 12'h0CC, 0);
    rd_chk("R4 fifo2 cleared", 12'h0D4, 0);
    pulse(3'b100, 3'b100);
    @(negedge clk); reg_wr = 1; reg_addr = 12'h0C8; reg_wdata = 32'h4;
    sbe_pulse = 3'b100; dbe_pulse = 3'b100;
    @(negedge clk); reg_wr = 0; sbe_pulse = '0; dbe_pulse = '0;
    rd_chk("R5 reset beats pulse", 12'h0D4, 0);
    wr(12'h024, 32'hFFFF_FFFF);
  endtask

  task automatic t_irq;
    pulse(3'b000, 3'b100);
    check("R8 masked irq", {31'b0, irq}, 0);
    wr(12'h020, 32'hFFFF_FFFF);
    rd_chk("R8 enable bits", 12'h020, 32'h00FC_0000);
    wr(12'h020, 32'h0040_0000);
    check("R8 other bit enabled", {31'b0, irq}, 0);
    pulse(3'b100, 3'b000);
    check("R8 irq raised", {31'b0, irq}, 1);
    wr(12'h024, 32'h0040_0000);
    check("R8 irq dropped", {31'b0, irq}, 0);
    wr(12'h024, 32'hFFFF_FFFF);
  endtask

  task automatic t_ignored;
    pulse(3'b001, 3'b000);
    wr(12'h0CC, 32'h1234_5678);
    rd_chk("R9 counter write ignored", 12'h0CC, 32'h0000_0001);
    rd_chk("R9 unmapped 0x040", 12'h040, 0);
    rd_chk("R9 unmapped 0x0D8", 12'h0D8, 0);
  endtask

  task automatic t_saturate;
    wr(12'h0C8, 32'h7);
    @(negedge clk); sbe_pulse = 3'b001;
    repeat (65540) @(negedge clk);
    sbe_pulse = '0;
    rd_chk("R3 saturated", 12'h0CC, 32'h0000_FFFF);
    pulse(3'b001, 3'b000);
    rd_chk("R3 no wrap", 12'h0CC, 32'h0000_FFFF);
    wr(12'h0C8, 32'h1);
    rd_chk("R4 clear after saturation", 12'h0CC, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset; t_count; t_status; t_clear; t_cfg; t_irq; t_ignored; t_saturate;
      end
      begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule